// File: doc/BRIEF.md
# Media Integer Arithmetic Unit

This unit carries out single-element integer operations used in audio and video kernels: rounding average, absolute difference, absolute difference added to an accumulator, minimum and maximum. Each operation takes two operands and an accumulator. Control inputs select the operation, the element width (8, 16 or 32 bits) and whether the operands are signed or unsigned.

Inputs are taken through a valid/ready handshake. The registered result and a 4-bit condition field appear one cycle after acceptance. Operands narrower than 32 bits contribute only their low bits. The result is sign-extended to 32 bits in signed mode and zero-extended in unsigned mode. When the record input is set, the condition field reports how the two inputs compare, whichever value the operation returns. The unit handles one element per operation; looping over vectors is left to the surrounding pipeline.

Top module: `media_alu`

## Requirements
- R1: Operation code 0 (rounding average) returns (a + b + 1) >> 1, computed one bit wider than the element so no carry is lost, then truncated to the element width. The other operation codes are 1 = absolute difference, 2 = absolute-difference accumulate, 3 = minimum and 4 = maximum.
- R2: Operation code 1 returns a - b when a > b and b - a otherwise, truncated to the element width. The comparison follows the signed/unsigned flag.
- R3: Operation code 2 returns acc + |a - b|, truncated to the element width. The sum wraps and does not saturate. The absolute difference uses the same signed or unsigned comparison as R2.
- R4: Operation code 3 returns a when a < b and b otherwise.
- R5: Operation code 4 returns a when a > b and b otherwise.
- R6: Width code 0 selects 8-bit elements, 1 selects 16-bit elements, and 2 (or 3) selects 32-bit elements. Operand bits above the element width are ignored. The 32-bit result is sign-extended when the signed flag is 1 and zero-extended when it is 0.
- R7: When the record input is 1 on an accepted operation, the condition output becomes {LT, GT, EQ, SO} on bits 3 down to 0, taken from comparing a with b. The codes are 4'b1000 for a < b, 4'b0100 for a > b and 4'b0010 for a == b. SO is always 0.
- R8: When the record input is 0 on an accepted operation, the condition output keeps its previous value. The result is still updated.
- R9: An operation is accepted on a rising clock edge where in_valid_i and in_ready_o are both 1. out_valid_o and the result follow on the next edge. Back-to-back operations flow with no gap while out_ready_i is 1.
- R10: While out_valid_o is 1 and out_ready_i is 0, in_ready_o is 0 and the result, condition and out_valid_o hold their values.
- R11: After reset, out_valid_o is 0, the result is 0, the condition output is 0 and in_ready_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operation request valid |
| in_ready_o | output | 1 | Unit can accept an operation |
| op_i | input | 3 | Operation code (R1) |
| width_i | input | 2 | Element width code (R6) |
| signed_i | input | 1 | 1 = signed elements |
| rec_i | input | 1 | 1 = update condition output |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| acc_i | input | 32 | Accumulator input |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes result |
| res_o | output | 32 | Extended result |
| cr_o | output | 4 | Condition field {LT, GT, EQ, SO} |

## Verification
The hardest case to reach from the ports is a new request that is held while the output register is stalled, followed by a release in which the old result is consumed and the waiting request is accepted on the same edge. The bench stalls out_ready_i and keeps a different request valid for several cycles. It then raises out_ready_i and checks that the second result replaces the first with no bubble. Boundary values such as the most negative element, all-ones 32-bit operands and accumulator overflow are placed in the vector table. In those cases a wrong extension or a lost carry changes the visible result.

// File: rtl/media_pkg.sv
package media_pkg;
  localparam int XLEN = 32;
  localparam int NW0  = 8;
  localparam int NW1  = 16;
  localparam int CR_W = 4;

  typedef enum logic [2:0] {
    OP_AVG    = 3'd0,
    OP_ABSD   = 3'd1,
    OP_ABSACC = 3'd2,
    OP_MIN    = 3'd3,
    OP_MAX    = 3'd4
  } media_op_e;

  typedef enum logic [1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2
  } elem_w_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_t;
endpackage

// File: rtl/media_narrow.sv
// Keeps the low element bits and extends them back to full width.
module media_narrow
  import media_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] data_i,
  input  logic [1:0]   width_i,
  input  logic         signed_i,
  output logic [W-1:0] data_o
);
  always_comb begin
    unique case (width_i)
      EW_8:    data_o = {{(W-NW0){signed_i & data_i[NW0-1]}}, data_i[NW0-1:0]};
      EW_16:   data_o = {{(W-NW1){signed_i & data_i[NW1-1]}}, data_i[NW1-1:0]};
      default: data_o = data_i;
    endcase
  end
endmodule

// File: rtl/media_cmp.sv
// Compares a with b from the sign and zero of b - a.
module media_cmp
  import media_pkg::*;
#(
  parameter int W = XLEN + 1
) (
  input  logic [W-1:0] ax_i,
  input  logic [W-1:0] bx_i,
  output cond_t        cond_o
);
  logic [W:0] diff;

  assign diff = {bx_i[W-1], bx_i} - {ax_i[W-1], ax_i};

  always_comb begin
    cond_o.gt = diff[W];
    cond_o.eq = (diff == '0);
    cond_o.lt = ~diff[W] & (diff != '0);
    cond_o.so = 1'b0;
  end
endmodule

// File: rtl/media_datapath.sv
module media_datapath
  import media_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W:0]   ax_i,
  input  logic [W:0]   bx_i,
  input  logic [W-1:0] acc_i,
  input  logic [2:0]   op_i,
  input  cond_t        cond_i,
  output logic [W-1:0] raw_o
);
  localparam int SW = W + 2;

  logic [SW-1:0] ae, be, sum, dab, dba;
  logic [W-1:0]  absd;

  assign ae   = {ax_i[W], ax_i};
  assign be   = {bx_i[W], bx_i};
  // carry-in of one gives round-half-up
  assign sum  = ae + be + {{(SW-1){1'b0}}, 1'b1};
  assign dab  = ae - be;
  assign dba  = be - ae;
  assign absd = cond_i.gt ? dab[W-1:0] : dba[W-1:0];

  always_comb begin
    unique case (op_i)
      OP_AVG:    raw_o = sum[W:1];
      OP_ABSD:   raw_o = absd;
      OP_ABSACC: raw_o = acc_i + absd;
      OP_MIN:    raw_o = cond_i.lt ? ax_i[W-1:0] : bx_i[W-1:0];
      OP_MAX:    raw_o = cond_i.gt ? ax_i[W-1:0] : bx_i[W-1:0];
      default:   raw_o = '0;
    endcase
  end
endmodule

// File: rtl/media_alu.sv
module media_alu
  import media_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  input  logic [2:0]      op_i,
  input  logic [1:0]      width_i,
  input  logic            signed_i,
  input  logic            rec_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] acc_i,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  output logic [XLEN-1:0] res_o,
  output logic [CR_W-1:0] cr_o
);
  logic [XLEN-1:0] an, bn, raw, res_d;
  logic [XLEN:0]   ax, bx;
  cond_t           cond;
  logic            accept;

  media_narrow #(.W(XLEN)) i_narrow_a (
    .data_i(a_i), .width_i(width_i), .signed_i(signed_i), .data_o(an)
  );
  media_narrow #(.W(XLEN)) i_narrow_b (
    .data_i(b_i), .width_i(width_i), .signed_i(signed_i), .data_o(bn)
  );

  // extra top bit makes one signed compare serve both modes
  assign ax = {signed_i & an[XLEN-1], an};
  assign bx = {signed_i & bn[XLEN-1], bn};

  media_cmp #(.W(XLEN+1)) i_cmp (
    .ax_i(ax), .bx_i(bx), .cond_o(cond)
  );

  media_datapath #(.W(XLEN)) i_dp (
    .ax_i(ax), .bx_i(bx), .acc_i(acc_i), .op_i(op_i),
    .cond_i(cond), .raw_o(raw)
  );

  media_narrow #(.W(XLEN)) i_narrow_r (
    .data_i(raw), .width_i(width_i), .signed_i(signed_i), .data_o(res_d)
  );

  assign in_ready_o = ~out_valid_o | out_ready_i;
  assign accept     = in_valid_i & in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      res_o       <= '0;
      cr_o        <= '0;
    end else begin
      if (accept) begin
        out_valid_o <= 1'b1;
        res_o       <= res_d;
        if (rec_i) cr_o <= cond;
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/media_alu_chk.sv
module media_alu_chk
  import media_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            in_valid_i,
  input logic            in_ready_o,
  input logic [2:0]      op_i,
  input logic [1:0]      width_i,
  input logic            rec_i,
  input logic [XLEN-1:0] a_i,
  input logic [XLEN-1:0] b_i,
  input logic            out_valid_o,
  input logic            out_ready_i,
  input logic [XLEN-1:0] res_o,
  input logic [CR_W-1:0] cr_o
);
  a_r7_so_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cr_o[0]);

  a_r7_cr_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cr_o[3:1]));

  a_r8_cr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_ready_o && rec_i) |=> $stable(cr_o));

  a_r9_accept_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o);

  a_r10_backpressure: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o);

  a_r10_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(res_o) && $stable(cr_o)));

  a_r4_min_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && op_i == OP_MIN && width_i == EW_32 && a_i == b_i)
      |=> res_o == $past(a_i));
endmodule

bind media_alu media_alu_chk i_media_alu_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
  .in_ready_o(in_ready_o), .op_i(op_i), .width_i(width_i), .rec_i(rec_i),
  .a_i(a_i), .b_i(b_i), .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .res_o(res_o), .cr_o(cr_o)
);

// File: tb/test_media_alu.sv
module test_media_alu;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  w;
    logic        sg;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] acc;
    logic [31:0] res;
    logic [3:0]  cr;
    logic [3:0]  req;
  } vec_t;

  // op: 0 avg 1 absd 2 absacc 3 min 4 max; w: 0=8 1=16 2=32; cr: 8 LT 4 GT 2 EQ
  localparam vec_t VECS [NVEC] = '{
    '{3'd0, 2'd0, 1'b0, 32'hFF, 32'h01, 32'h0, 32'h00000080, 4'h4, 4'd1},       // R1 carry kept
    '{3'd0, 2'd0, 1'b1, 32'h7F, 32'h7F, 32'h0, 32'h0000007F, 4'h2, 4'd1},       // R1
    '{3'd0, 2'd0, 1'b1, 32'h80, 32'hFF, 32'h0, 32'hFFFFFFC0, 4'h8, 4'd1},       // R1 signed
    '{3'd0, 2'd2, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF, 4'h2, 4'd1}, // R1 33-bit
    '{3'd0, 2'd1, 1'b1, 32'h12347FFF, 32'h0001, 32'h0, 32'h00004000, 4'h4, 4'd6}, // R6 low bits
    '{3'd1, 2'd0, 1'b0, 32'h10, 32'hF0, 32'h0, 32'h000000E0, 4'h8, 4'd2},       // R2 unsigned
    '{3'd1, 2'd0, 1'b1, 32'h10, 32'hF0, 32'h0, 32'h00000020, 4'h4, 4'd2},       // R2 signed
    '{3'd1, 2'd1, 1'b1, 32'h7FFF, 32'h8000, 32'h0, 32'hFFFFFFFF, 4'h4, 4'd2},   // R2 truncate
    '{3'd1, 2'd2, 1'b0, 32'd5, 32'd5, 32'h0, 32'h0, 4'h2, 4'd2},                // R2 equal
    '{3'd2, 2'd0, 1'b0, 32'd3, 32'd10, 32'hFE, 32'h00000005, 4'h8, 4'd3},       // R3 wrap 8
    '{3'd2, 2'd1, 1'b1, 32'hFFFE, 32'h0003, 32'h10, 32'h00000015, 4'h8, 4'd3},  // R3 signed
    '{3'd2, 2'd2, 1'b0, 32'd100, 32'd40, 32'hFFFFFFF0, 32'h0000002C, 4'h4, 4'd3}, // R3 wrap 32
    '{3'd3, 2'd0, 1'b1, 32'h80, 32'h01, 32'h0, 32'hFFFFFF80, 4'h8, 4'd4},       // R4 signed
    '{3'd3, 2'd0, 1'b0, 32'h80, 32'h01, 32'h0, 32'h00000001, 4'h4, 4'd4},       // R4 unsigned
    '{3'd4, 2'd0, 1'b1, 32'h80, 32'h01, 32'h0, 32'h00000001, 4'h8, 4'd5},       // R5 signed
    '{3'd4, 2'd1, 1'b0, 32'h8000, 32'h0001, 32'h0, 32'h00008000, 4'h4, 4'd5},   // R5 unsigned
    '{3'd4, 2'd2, 1'b1, 32'hFFFFFFFF, 32'h0, 32'h0, 32'h00000000, 4'h8, 4'd5},  // R5 32-bit
    '{3'd3, 2'd2, 1'b1, 32'd7, 32'd7, 32'h0, 32'h00000007, 4'h2, 4'd4}          // R4 equal, R7 EQ
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  op = '0;
  logic [1:0]  width = '0;
  logic        sgn = 1'b0;
  logic        rec = 1'b0;
  logic [31:0] a = '0, b = '0, acc = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] res;
  logic [3:0]  cr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  media_alu i_media_alu (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_i(op), .width_i(width), .signed_i(sgn), .rec_i(rec),
    .a_i(a), .b_i(b), .acc_i(acc), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .res_o(res), .cr_o(cr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] o, input logic [1:0] w, input logic s,
                       input logic r, input logic [31:0] va, input logic [31:0] vb,
                       input logic [31:0] vacc);
    op = o; width = w; sgn = s; rec = r; a = va; b = vb; acc = vacc;
  endtask

  task automatic run_op(input logic [2:0] o, input logic [1:0] w, input logic s,
                        input logic r, input logic [31:0] va, input logic [31:0] vb,
                        input logic [31:0] vacc);
    @(negedge clk);
    drive(o, w, s, r, va, vb, vacc);
    in_valid = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 out_valid", {31'b0, out_valid}, 32'd0);
    check("R11 res", res, 32'd0);
    check("R11 cr", {28'b0, cr}, 32'd0);
    check("R11 in_ready", {31'b0, in_ready}, 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      run_op(VECS[i].op, VECS[i].w, VECS[i].sg, 1'b1, VECS[i].a, VECS[i].b, VECS[i].acc);
      check($sformatf("R%0d vec%0d res", VECS[i].req, i), res, VECS[i].res);
      check($sformatf("R7 vec%0d cr", i), {28'b0, cr}, {28'b0, VECS[i].cr});
      check($sformatf("R9 vec%0d valid", i), {31'b0, out_valid}, 32'd1);
    end

    // R8: record clear keeps cr (last vector left EQ)
    run_op(3'd4, 2'd0, 1'b0, 1'b0, 32'd1, 32'd2, 32'd0);
    check("R8 res updated", res, 32'd2);
    check("R8 cr held", {28'b0, cr}, 32'h2);

    // R10 stall with a second request pending, then R9 same-edge handoff
    @(negedge clk);
    out_ready = 1'b0;
    drive(3'd0, 2'd0, 1'b0, 1'b1, 32'd2, 32'd4, 32'd0);
    in_valid = 1'b1;
    @(posedge clk);
    #1 drive(3'd1, 2'd0, 1'b0, 1'b1, 32'd9, 32'd1, 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R10 valid held", {31'b0, out_valid}, 32'd1);
      check("R10 in_ready low", {31'b0, in_ready}, 32'd0);
      check("R10 res held", res, 32'd3);
      check("R10 cr held", {28'b0, cr}, 32'h8);
    end
    out_ready = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    check("R9 handoff valid", {31'b0, out_valid}, 32'd1);
    check("R9 handoff res", res, 32'd8);
    check("R7 handoff cr", {28'b0, cr}, 32'h4);
    @(negedge clk);
    check("R9 drained", {31'b0, out_valid}, 32'd0);

    // R6 unsigned 32-bit keeps top bit without extension
    run_op(3'd4, 2'd3, 1'b0, 1'b1, 32'h80000000, 32'h1, 32'h0);
    check("R6 width3 unsigned", res, 32'h80000000);
    check("R7 width3 cr", {28'b0, cr}, 32'h4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule